// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block produces a set of gated clock outputs and stops or restarts them cleanly in response to active-low stop requests. The outputs form two groups, a CPU group and a PCI group, and there is also one free-running PCI reference clock. All waveforms are derived from a single fast system clock `clk` by a shared phase counter. The CPU half period is `CPU_HALF` system cycles and the PCI half period is `PCI_HALF` system cycles. `PCI_HALF` must be a multiple of `CPU_HALF`, so that every PCI rising edge is also a CPU rising edge.

Each request is first passed through a two-flop synchronizer. Once a group sees a change in its request, it waits for a rising edge of the reference clock. It then changes state on the next falling edge of its own clock, so the last high phase is never cut short. Stopped outputs always sit low.

A power-down request stops everything, including the reference clock, using the same edge ordering. On release, the outputs come back only after a restart delay. That delay is counted on `clk` and is derived from the `SYS_FREQ_KHZ` and `RESTART_US` parameters. A write-only mask register holds one enable bit per gated output, and a cleared bit forces that output low at once, outside the edge sequencing.

Top module: `clkStopGen`

## Requirements
- R1: After reset, with all three requests high (inactive), every output toggles. Each CPU output has a period of 2*CPU_HALF `clk` cycles, and each PCI output and `pciFClk` have a period of 2*PCI_HALF cycles. `cpuRunning`, `pciRunning` and `oscRunning` read 1.
- R2: Any high pulse on a gated output or on `pciFClk` lasts exactly its full half period. The one exception is a pulse cut by clearing an enable bit.
- R3: A change on `cpuStopN` or `pciStopN` passes through two synchronizer flops. The group then waits for the first rising edge of `pciFClk` that follows. The group's status output and gate then change together with the next falling edge of its own clock, which comes exactly one own half period after that rising edge.
- R4: `cpuStopN` affects only `cpuClk`, and `pciStopN` affects only `pciClk`. `pciFClk` keeps running while either group is stopped. A stopped group holds all of its outputs at 0.
- R5: A low level on `pwrDownN` is synchronized, armed on the next rising edge of `pciFClk`, and acted on at the following falling edge of `pciFClk`. At that point `oscRunning` goes to 0 and every output, `pciFClk` included, stays at 0.
- R6: After `pwrDownN` returns high, `oscRunning` rises after exactly PD+2 `clk` edges, where PD = SYS_FREQ_KHZ*RESTART_US/1000. The first sample after that rise shows `pciFClk` high, starting a full-width pulse.
- R7: On a `clk` edge with `enWr` high, `enData` is loaded into the enable mask. Bit i (i < N_CPU) controls `cpuClk[i]`, and bit N_CPU+j controls `pciClk[j]`. A 0 forces that output low from that same edge onward. The mask resets to all ones, and `enData` is ignored while `enWr` is low.
- R8: A stop request held while power-down is in effect applies directly when the outputs restart. A group requested off stays at 0 after restart, and its status already reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock from which all outputs are derived |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuStopN | input | 1 | Active-low stop request for the CPU group |
| pciStopN | input | 1 | Active-low stop request for the gated PCI group |
| pwrDownN | input | 1 | Active-low power-down request |
| enWr | input | 1 | Write strobe for the enable mask |
| enData | input | N_CPU+N_PCI | New enable mask (CPU bits low, PCI bits high) |
| cpuClk | output | N_CPU | Gated CPU clock outputs |
| pciClk | output | N_PCI | Gated PCI clock outputs |
| pciFClk | output | 1 | Free-running PCI reference clock |
| cpuRunning | output | 1 | 1 while the CPU group gate is open |
| pciRunning | output | 1 | 1 while the PCI group gate is open |
| oscRunning | output | 1 | 0 while power-down is in effect |

## Verification
The sequencing assertions assume the request pins stay stable long enough for the synchronizers to settle. They also assume that `PCI_HALF` is a multiple of `CPU_HALF`, so that gate changes always coincide with a phase in which the level is low.

The bench changes every request only on a falling edge of `clk`. It then leaves each request untouched until the matching status output has changed. During power-down it toggles nothing except the stop request being tested.

The pulse-width monitor is paused while enable bits are being swept, because that path is allowed to truncate pulses.

// File: rtl/clkStopPkg.sv
package clkStopPkg;
  // Control to datapath: gate levels
  typedef struct packed {
    logic oscOn;
    logic cpuGate;
    logic pciGate;
  } gateCmd_t;

  // Datapath to control: edge strobes, valid in the cycle before the edge lands
  typedef struct packed {
    logic pciRise;
    logic pciFall;
    logic cpuFall;
  } edgeEv_t;
endpackage

// File: rtl/clkStopSync.sv
module clkStopSync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic stage1, stage2;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1 <= 1'b1;
        stage2 <= 1'b1;
      end else begin
        stage1 <= din[b];
        stage2 <= stage1;
      end
    end
    assign dout[b] = stage2;
  end
endmodule

// File: rtl/clkStopSeq.sv
module clkStopSeq (
  input  logic clk,
  input  logic rstN,
  input  logic oscOn,
  input  logic wantRun,
  input  logic armEv,
  input  logic fireEv,
  output logic gate
);
  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gate  <= 1'b1;
      armed <= 1'b0;
    end else if (!oscOn) begin
      gate  <= wantRun;   // nothing toggles, so follow the request directly
      armed <= 1'b0;
    end else if (wantRun == gate) begin
      armed <= 1'b0;
    end else if (armed && fireEv) begin
      gate  <= wantRun;
      armed <= 1'b0;
    end else if (armEv) begin
      armed <= 1'b1;
    end
  end

  // R3: while running, a gate change needs a prior arming edge plus a fire edge
  a_r3_fire_after_arm: assert property (@(posedge clk) disable iff (!rstN)
    ((gate != $past(gate)) && $past(oscOn)) |-> ($past(armed) && $past(fireEv)));
endmodule

// File: rtl/clkStopCtrl.sv
module clkStopCtrl
  import clkStopPkg::*;
#(
  parameter int PD_CYCLES = 500000
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     cpuStopN,
  input  logic     pciStopN,
  input  logic     pwrDownN,
  input  edgeEv_t  ev,
  output gateCmd_t cmd
);
  localparam int PW = $clog2(PD_CYCLES + 1);

  logic [2:0]    syncQ;
  logic          oscOn, pdArmed;
  logic [PW-1:0] pdCnt;
  logic          cpuGate, pciGate;

  clkStopSync #(.W(3)) u_sync (
    .clk(clk), .rstN(rstN),
    .din({cpuStopN, pciStopN, pwrDownN}),
    .dout(syncQ)
  );

  clkStopSeq u_cpuSeq (
    .clk(clk), .rstN(rstN), .oscOn(oscOn), .wantRun(syncQ[2]),
    .armEv(ev.pciRise), .fireEv(ev.cpuFall), .gate(cpuGate)
  );

  clkStopSeq u_pciSeq (
    .clk(clk), .rstN(rstN), .oscOn(oscOn), .wantRun(syncQ[1]),
    .armEv(ev.pciRise), .fireEv(ev.pciFall), .gate(pciGate)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oscOn   <= 1'b1;
      pdArmed <= 1'b0;
      pdCnt   <= '0;
    end else if (oscOn) begin
      pdCnt <= '0;
      if (syncQ[0]) begin
        pdArmed <= 1'b0;
      end else if (pdArmed && ev.pciFall) begin
        oscOn   <= 1'b0;
        pdArmed <= 1'b0;
      end else if (ev.pciRise) begin
        pdArmed <= 1'b1;
      end
    end else begin
      if (!syncQ[0]) begin
        pdCnt <= '0;
      end else if (pdCnt == PW'(PD_CYCLES - 1)) begin
        oscOn <= 1'b1;
        pdCnt <= '0;
      end else begin
        pdCnt <= pdCnt + 1'b1;
      end
    end
  end

  assign cmd = '{oscOn: oscOn, cpuGate: cpuGate, pciGate: pciGate};

  // R5: power-down lands only on a reference falling edge after arming
  a_r5_off_on_ref_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(oscOn) |-> ($past(pdArmed) && $past(ev.pciFall)));

  // R6: restart only once the latency counter has reached its terminal count
  a_r6_restart_after_count: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oscOn) |-> ($past(pdCnt) == PW'(PD_CYCLES - 1)));
endmodule

// File: rtl/clkStopDp.sv
module clkStopDp
  import clkStopPkg::*;
#(
  parameter int N_CPU    = 4,
  parameter int N_PCI    = 7,
  parameter int CPU_HALF = 2,
  parameter int PCI_HALF = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  gateCmd_t               cmd,
  input  logic                   enWr,
  input  logic [N_CPU+N_PCI-1:0] enData,
  output edgeEv_t                ev,
  output logic [N_CPU-1:0]       cpuClk,
  output logic [N_PCI-1:0]       pciClk,
  output logic                   pciFClk
);
  localparam int N_OUT   = N_CPU + N_PCI;
  localparam int CPU_PER = 2 * CPU_HALF;
  localparam int PCI_PER = 2 * PCI_HALF;
  localparam int CW      = $clog2(PCI_PER);

  logic [CW-1:0]    cnt, cntNext;
  logic [N_OUT-1:0] enMask;
  logic             cpuLvl, pciLvl;
  int               nextInt;

  assign cntNext = (cnt == CW'(PCI_PER - 1)) ? '0 : cnt + 1'b1;
  assign nextInt = int'(cntNext);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (!cmd.oscOn) cnt <= '0;
    else                 cnt <= cntNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     enMask <= '1;
    else if (enWr) enMask <= enData;
  end

  assign pciLvl = int'(cnt) < PCI_HALF;
  assign cpuLvl = (int'(cnt) % CPU_PER) < CPU_HALF;

  assign ev.pciRise = cmd.oscOn && (nextInt == 0);
  assign ev.pciFall = cmd.oscOn && (nextInt == PCI_HALF);
  assign ev.cpuFall = cmd.oscOn && ((nextInt % CPU_PER) == CPU_HALF);

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    assign cpuClk[i] = cpuLvl & cmd.cpuGate & cmd.oscOn & enMask[i];
  end
  for (genvar j = 0; j < N_PCI; j++) begin : g_pci
    assign pciClk[j] = pciLvl & cmd.pciGate & cmd.oscOn & enMask[N_CPU+j];
  end
  assign pciFClk = pciLvl & cmd.oscOn;

  // R2: gate changes while running only coincide with a low level
  a_r2_cpu_gate_on_low: assert property (@(posedge clk) disable iff (!rstN)
    ((cmd.cpuGate != $past(cmd.cpuGate)) && $past(cmd.oscOn) && cmd.oscOn) |-> !cpuLvl);
  a_r2_pci_gate_on_low: assert property (@(posedge clk) disable iff (!rstN)
    ((cmd.pciGate != $past(cmd.pciGate)) && $past(cmd.oscOn) && cmd.oscOn) |-> !pciLvl);
endmodule

// File: rtl/clkStopGen.sv
module clkStopGen
  import clkStopPkg::*;
#(
  parameter int N_CPU        = 4,
  parameter int N_PCI        = 7,
  parameter int CPU_HALF     = 2,
  parameter int PCI_HALF     = 4,
  parameter int SYS_FREQ_KHZ = 250000,
  parameter int RESTART_US   = 2000
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cpuStopN,
  input  logic                   pciStopN,
  input  logic                   pwrDownN,
  input  logic                   enWr,
  input  logic [N_CPU+N_PCI-1:0] enData,
  output logic [N_CPU-1:0]       cpuClk,
  output logic [N_PCI-1:0]       pciClk,
  output logic                   pciFClk,
  output logic                   cpuRunning,
  output logic                   pciRunning,
  output logic                   oscRunning
);
  localparam int PD_CYCLES = SYS_FREQ_KHZ * RESTART_US / 1000;

  gateCmd_t cmd;
  edgeEv_t  ev;

  clkStopCtrl #(.PD_CYCLES(PD_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuStopN(cpuStopN), .pciStopN(pciStopN),
    .pwrDownN(pwrDownN), .ev(ev), .cmd(cmd)
  );

  clkStopDp #(.N_CPU(N_CPU), .N_PCI(N_PCI), .CPU_HALF(CPU_HALF), .PCI_HALF(PCI_HALF)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .enWr(enWr), .enData(enData),
    .ev(ev), .cpuClk(cpuClk), .pciClk(pciClk), .pciFClk(pciFClk)
  );

  assign cpuRunning = cmd.cpuGate;
  assign pciRunning = cmd.pciGate;
  assign oscRunning = cmd.oscOn;
endmodule

// File: tb/clkStopGen_tb.sv
module clkStopGen_tb;
  localparam int N_CPU = 4, N_PCI = 7, CH = 2, PH = 4;
  localparam int NO = N_CPU + N_PCI;
  localparam int PD = 250000 * 1 / 1000;

  logic clk = 1'b0, rstN = 1'b0;
  logic cpuStopN = 1'b1, pciStopN = 1'b1, pwrDownN = 1'b1, enWr = 1'b0;
  logic [NO-1:0] enData = '1;
  logic [N_CPU-1:0] cpuClk;
  logic [N_PCI-1:0] pciClk;
  logic pciFClk, cpuRunning, pciRunning, oscRunning;

  int nRun = 0, nFail = 0;
  bit monOn = 1'b0, done = 1'b0;

  clkStopGen #(.N_CPU(N_CPU), .N_PCI(N_PCI), .CPU_HALF(CH), .PCI_HALF(PH),
               .SYS_FREQ_KHZ(250000), .RESTART_US(1)) u_dut (
    .clk(clk), .rstN(rstN), .cpuStopN(cpuStopN), .pciStopN(pciStopN),
    .pwrDownN(pwrDownN), .enWr(enWr), .enData(enData), .cpuClk(cpuClk),
    .pciClk(pciClk), .pciFClk(pciFClk), .cpuRunning(cpuRunning),
    .pciRunning(pciRunning), .oscRunning(oscRunning)
  );

  always #2 clk = ~clk;  // 250 MHz

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Width monitor (R2): three watched outputs, checked just after each edge
  int  runLen [3];
  bit  valid  [3];
  bit  prevW  [3];
  int  widthErr = 0;
  always begin
    @(posedge clk); #1;
    for (int k = 0; k < 3; k++) begin
      bit cur;
      int half;
      cur  = (k == 0) ? cpuClk[0] : (k == 1) ? pciClk[0] : pciFClk;
      half = (k == 0) ? CH : PH;
      if (!monOn) valid[k] = 1'b0;
      if (cur && !prevW[k]) begin runLen[k] = 1; valid[k] = monOn; end
      else if (cur) runLen[k]++;
      else if (prevW[k] && valid[k] && runLen[k] != half) begin
        widthErr++;
        $display("FAIL R2 pulse width on output %0d: actual %0d expected %0d", k, runLen[k], half);
      end
      prevW[k] = cur;
    end
  end

  task automatic countRises(input int n, output int cc, output int cp, output int cr);
    logic a, b, c;
    cc = 0; cp = 0; cr = 0;
    @(negedge clk);
    a = cpuClk[0]; b = pciClk[0]; c = pciFClk;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (cpuClk[0] && !a) cc++;
      if (pciClk[0] && !b) cp++;
      if (pciFClk && !c) cr++;
      a = cpuClk[0]; b = pciClk[0]; c = pciFClk;
    end
  endtask

  // R3: drive a request, then check the edge ordering of the status change
  task automatic seqCheck(input bit isCpu, input bit stopIt);
    int lastRise, idx, half;
    logic prevRef, st, gclk;
    bit found;
    half = isCpu ? CH : PH;
    @(negedge clk);
    if (isCpu) cpuStopN = !stopIt; else pciStopN = !stopIt;
    prevRef = pciFClk; lastRise = -1; found = 0; idx = 0;
    for (int i = 1; i <= 80 && !found; i++) begin
      @(negedge clk);
      idx = i;
      if (pciFClk && !prevRef) lastRise = i;
      prevRef = pciFClk;
      st   = isCpu ? cpuRunning : pciRunning;
      gclk = isCpu ? cpuClk[0] : pciClk[0];
      if (st == !stopIt) begin
        found = 1;
        check(gclk == 1'b0, "R3", "group clock low at gate change", gclk, 0);
      end
    end
    check(found, "R3", "status changed", found, 1);
    check(lastRise >= 3 && lastRise <= 2 + 2*PH, "R3", "arming reference rise cycle", lastRise, 3);
    check(idx - lastRise == half, "R3", "fall after reference rise", idx - lastRise, half);
  endtask

  initial begin
    int cc, cp, cr, idx, lastRise;
    logic prevRef;
    bit found;
    for (int k = 0; k < 3; k++) begin runLen[k] = 0; valid[k] = 0; prevW[k] = 0; end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(cpuRunning && pciRunning && oscRunning, "R1", "status after reset",
          {cpuRunning, pciRunning, oscRunning}, 7);
    monOn = 1'b1;

    countRises(32, cc, cp, cr);
    check(cc == 8, "R1", "cpu rises", cc, 8);
    check(cp == 4, "R1", "pci rises", cp, 4);
    check(cr == 4, "R1", "ref rises", cr, 4);

    // CPU group stop / restart
    seqCheck(1'b1, 1'b1);
    countRises(32, cc, cp, cr);
    check(cc == 0 && cpuClk == '0, "R4", "cpu held low while stopped", cc, 0);
    check(cp == 4, "R4", "pci unaffected by cpu stop", cp, 4);
    check(cr == 4, "R4", "ref unaffected by cpu stop", cr, 4);
    seqCheck(1'b1, 1'b0);
    countRises(32, cc, cp, cr);
    check(cc == 8, "R3", "cpu restarted", cc, 8);

    // PCI group stop / restart
    seqCheck(1'b0, 1'b1);
    countRises(32, cc, cp, cr);
    check(cp == 0 && pciClk == '0, "R4", "pci held low while stopped", cp, 0);
    check(cc == 8, "R4", "cpu unaffected by pci stop", cc, 8);
    check(cr == 4, "R4", "ref unaffected by pci stop", cr, 4);
    seqCheck(1'b0, 1'b0);
    countRises(32, cc, cp, cr);
    check(cp == 4, "R3", "pci restarted", cp, 4);

    // Enable mask sweep (R7)
    monOn = 1'b0;
    for (int k = 0; k < NO; k++) begin
      logic [NO-1:0] outs;
      @(negedge clk);
      enWr = 1'b1; enData = ~(NO'(1) << k);
      @(negedge clk);
      enWr = 1'b0;
      outs = {pciClk, cpuClk};
      check(outs[k] == 1'b0, "R7", $sformatf("bit %0d forced low at write edge", k), outs[k], 0);
      for (int s = 0; s < 2*PH; s++) begin
        @(negedge clk);
        outs = {pciClk, cpuClk};
        if (outs[k] != 1'b0)
          check(1'b0, "R7", $sformatf("bit %0d stays low", k), outs[k], 0);
      end
    end
    @(negedge clk);
    enWr = 1'b1; enData = '1;
    @(negedge clk);
    enWr = 1'b0; enData = '0;   // ignored while enWr low
    countRises(32, cc, cp, cr);
    check(cc == 8 && cp == 4, "R7", "mask kept with enWr low", cc + cp, 12);
    repeat (16) @(negedge clk);
    monOn = 1'b1;

    // Power-down (R5)
    @(negedge clk);
    pwrDownN = 1'b0;
    prevRef = pciFClk; lastRise = -1; found = 0; idx = 0;
    for (int i = 1; i <= 80 && !found; i++) begin
      @(negedge clk);
      idx = i;
      if (pciFClk && !prevRef) lastRise = i;
      if (!oscRunning) begin
        found = 1;
        check(prevRef == 1'b1, "R5", "ref was high just before stop", prevRef, 1);
      end
      prevRef = pciFClk;
    end
    check(found, "R5", "oscRunning fell", found, 1);
    check(idx - lastRise == PH, "R5", "stop at ref fall", idx - lastRise, PH);
    cpuStopN = 1'b0;   // R8: stop request during power-down
    countRises(40, cc, cp, cr);
    check(cc + cp + cr == 0 && pciFClk == 0, "R5", "all outputs low", cc + cp + cr, 0);

    // Release (R6)
    @(negedge clk);
    pwrDownN = 1'b1;
    repeat (PD + 1) @(negedge clk);
    check(oscRunning == 1'b0, "R6", "still off one edge early", oscRunning, 0);
    @(negedge clk);
    check(oscRunning == 1'b1, "R6", "on after PD+2 edges", oscRunning, 1);
    check(pciFClk == 1'b1, "R6", "ref starts high", pciFClk, 1);
    check(cpuRunning == 1'b0 && pciRunning == 1'b1, "R8", "group states on restart",
          {cpuRunning, pciRunning}, 1);
    countRises(32, cc, cp, cr);
    check(cc == 0, "R8", "cpu stays stopped after restart", cc, 0);
    check(cp == 4 && cr == 4, "R8", "pci and ref run after restart", cp + cr, 8);
    seqCheck(1'b1, 1'b0);
    countRises(32, cc, cp, cr);
    check(cc == 8, "R8", "cpu restarted after power-down", cc, 8);

    check(widthErr == 0, "R2", "no truncated high pulse", widthErr, 0);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule